// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

This block is one 32-bit timer channel. It has three registers: a reload constant, a live counter and a control word, plus an optional capture register. Software reaches them through a simple word-addressed register bus with a write strobe and a read path that is valid in the same cycle. While the channel's `run` input is high, a prescaler makes ticks at one of five power-of-four rates. Each tick moves the counter down by one. A tick that finds the counter at zero reloads it from the constant register and sets a sticky underflow flag.

The interrupt output is a level signal. It is high while the underflow flag and the interrupt-enable bit are both set. Software clears the flag by writing the control word with the flag bit at zero. A control write that carries an illegal encoding is refused as a whole and raises `wrErr` in the same cycle.

Two parameters select build options. `HAS_CAPT` adds the capture register and capture control values. `HAS_EXT` allows divider codes that take ticks from the `extTick` strobe instead of the prescaler, and allows a nonzero edge-select field. The defaults are capture present and external clocking absent.

Top module: `downcount_timer`

## Requirements
- R1: After reset the constant and counter registers read 0xFFFFFFFF, the control word reads 0 and `irq` is low.
- R2: Bus word addresses select registers as follows: 0 is the constant, 1 is the counter, 2 is the control word and 3 is the capture register. A write stores the data and a read returns it in the same cycle. With the capture option, address 3 is a plain read/write register. Without it, a write to address 3 raises `wrErr` and a read returns 0.
- R3: Control bits [2:0] select the tick period while `run` is high: code 0 gives 4 cycles, 1 gives 16, 2 gives 64, 3 gives 256 and 4 gives 1024. A legal control write that changes the code restarts the prescaler, so the next tick comes a full new period later.
- R4: On each tick, a nonzero counter decrements by one. A counter write in the same cycle takes priority over the tick.
- R5: A tick while the counter holds 0 loads the counter from the constant register and sets the underflow flag. The flag is visible as control bit 8.
- R6: While `run` is low, no ticks occur, and both the counter and the prescaler position hold their values.
- R7: A legal control write with bit 8 at 0 clears the flag. With bit 8 at 1 the flag is left as it was. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: `irq` equals the underflow flag ANDed with control bit 5 (interrupt enable). It follows control writes directly.
- R9: A control write is illegal, raises `wrErr` in its cycle, and changes neither the control fields nor the flag, if any of these holds:
  - any bit from 10 upward is set;
  - divider code 5 is written;
  - divider code 6 or 7 is written without the external option;
  - edge select [4:3] is nonzero without the external option;
  - capture control [7:6] equals 1;
  - capture control is 2 or 3 without the capture option;
  - bit 9 is set without the capture option.
- R10: With the capture option, capture control values 2 and 3 are stored, and a written bit 9 is discarded so that it reads back as 0. Legal writes keep `wrErr` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel start; low freezes counting |
| extTick | input | 1 | Pre-detected external tick strobe (used only with the external option) |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| wrErr | output | 1 | High during an illegal write |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the following counter and flag rules:
- the counter holds while stopped;
- the counter decrements or reloads on a tick;
- the flag stays set until a clearing write;
- a refused control write leaves the control fields and the flag untouched;
- the flag only rises while running;
- `irq` never rises without the flag.

Other behaviours only the bench scenarios can show, by counting cycles against a behavioural model:
- the exact tick period for each divider code;
- the prescaler restart after a code change;
- the race between an underflow and a clearing write;
- the readback of each register.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int ADDR_W   = 2;
  localparam int FLAG_BIT = 8;
  localparam int CFLG_BIT = 9;
  localparam int USED_W   = 10;
  localparam int NUM_DIV  = 5;

  typedef enum logic [ADDR_W-1:0] {
    REG_CONST = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_CAPT  = 2'd3
  } regSel_e;

  // stored control fields, packed so that bit positions match the control word
  typedef struct packed {
    logic [1:0] captCtl;  // [7:6]
    logic       irqEn;    // [5]
    logic [1:0] edgeSel;  // [4:3]
    logic [2:0] divCode;  // [2:0]
  } ctrlFields_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldConst;
    logic ldCount;
    logic ldCapt;
    logic tick;
  } dpStrobe_t;
endpackage

// File: rtl/dtmr_prescale.sv
module dtmr_prescale
  import dtmr_pkg::*;
#(
  parameter bit HAS_EXT = 1'b0,
  parameter int NDIV    = NUM_DIV
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       extTick,
  input  logic [2:0] divCode,
  input  logic       restart,
  output logic       tick
);
  localparam int PRE_W = 2 * NDIV;

  logic [PRE_W-1:0] preQ;
  logic [PRE_W-1:0] preLast;
  logic             extSel;
  logic             preHit;

  // last prescaler position for each power-of-four divider
  always_comb begin
    preLast = '0;
    for (int i = 0; i < NDIV; i++) begin
      if (divCode == 3'(i)) preLast = PRE_W'((1 << (2 * i + 2)) - 1);
    end
  end

  assign extSel = HAS_EXT && (divCode[2:1] == 2'b11);
  assign preHit = (preQ == preLast);
  assign tick   = run && (extSel ? extTick : preHit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preQ <= '0;
    end else if (restart) begin
      preQ <= '0;
    end else if (run && !extSel) begin
      preQ <= preHit ? '0 : preQ + 1'b1;
    end
  end
endmodule

// File: rtl/dtmr_ctrl.sv
module dtmr_ctrl
  import dtmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit HAS_CAPT = 1'b1,
  parameter bit HAS_EXT  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic              extTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              cntZero,
  input  logic [CNT_W-1:0]  constVal,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  captVal,
  output dpStrobe_t         stb,
  output logic [CNT_W-1:0]  rdData,
  output logic              wrErr,
  output logic              irq,
  output ctrlFields_t       ctrlVal,
  output logic              flagVal
);
  ctrlFields_t ctrlQ;
  ctrlFields_t ctrlNew;
  logic        flagQ;
  logic        ctrlSel;
  logic        resvBad, codeBad, edgeBad, capBad, cflgBad;
  logic        ctrlIllegal, captIllegal;
  logic        ctrlLoad;
  logic        restart;
  logic        tick;
  logic        underflow;

  assign ctrlNew = ctrlFields_t'(wrData[7:0]);
  assign ctrlSel = wrEn && (addr == REG_CTRL);

  // legality of a control write
  always_comb begin
    resvBad = |wrData[CNT_W-1:USED_W];
    if (ctrlNew.divCode <= 3'd4)      codeBad = 1'b0;
    else if (ctrlNew.divCode == 3'd5) codeBad = 1'b1;
    else                              codeBad = !HAS_EXT;
    edgeBad = !HAS_EXT && (ctrlNew.edgeSel != 2'd0);
    capBad  = (ctrlNew.captCtl == 2'd1) || (!HAS_CAPT && ctrlNew.captCtl[1]);
    cflgBad = !HAS_CAPT && wrData[CFLG_BIT];
  end

  assign ctrlIllegal = resvBad || codeBad || edgeBad || capBad || cflgBad;
  assign captIllegal = wrEn && (addr == REG_CAPT) && !HAS_CAPT;
  assign ctrlLoad    = ctrlSel && !ctrlIllegal;
  assign wrErr       = (ctrlSel && ctrlIllegal) || captIllegal;
  assign restart     = ctrlLoad && (ctrlNew.divCode != ctrlQ.divCode);

  dtmr_prescale #(.HAS_EXT(HAS_EXT), .NDIV(NUM_DIV)) i_pre (
    .clk     (clk),
    .rstN    (rstN),
    .run     (run),
    .extTick (extTick),
    .divCode (ctrlQ.divCode),
    .restart (restart),
    .tick    (tick)
  );

  assign underflow = tick && cntZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      flagQ <= 1'b0;
    end else begin
      if (ctrlLoad) ctrlQ <= ctrlNew;
      if (underflow)                             flagQ <= 1'b1;
      else if (ctrlLoad && !wrData[FLAG_BIT])    flagQ <= 1'b0;
    end
  end

  always_comb begin
    stb.ldConst = wrEn && (addr == REG_CONST);
    stb.ldCount = wrEn && (addr == REG_COUNT);
    stb.ldCapt  = wrEn && (addr == REG_CAPT) && HAS_CAPT;
    stb.tick    = tick;
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      REG_CONST: rdData = constVal;
      REG_COUNT: rdData = cntVal;
      REG_CTRL: begin
        rdData[7:0]      = ctrlQ;
        rdData[FLAG_BIT] = flagQ;
      end
      default:   rdData = captVal;
    endcase
  end

  assign irq     = flagQ && ctrlQ.irqEn;
  assign ctrlVal = ctrlQ;
  assign flagVal = flagQ;
endmodule

// File: rtl/dtmr_datapath.sv
module dtmr_datapath
  import dtmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit HAS_CAPT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] constVal,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] captVal,
  output logic             cntZero
);
  logic [CNT_W-1:0] constQ;
  logic [CNT_W-1:0] cntQ;

  assign cntZero = (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      constQ <= '1;
      cntQ   <= '1;
    end else begin
      if (stb.ldConst) constQ <= wrData;
      if (stb.ldCount)   cntQ <= wrData;
      else if (stb.tick) cntQ <= cntZero ? constQ : cntQ - 1'b1;
    end
  end

  generate
    if (HAS_CAPT) begin : g_capt
      logic [CNT_W-1:0] captQ;
      always_ff @(posedge clk) begin
        if (!rstN)          captQ <= '0;
        else if (stb.ldCapt) captQ <= wrData;
      end
      assign captVal = captQ;
    end else begin : g_nocapt
      assign captVal = '0;
    end
  endgenerate

  assign constVal = constQ;
  assign cntVal   = cntQ;
endmodule

// File: rtl/downcount_timer.sv
module downcount_timer
  import dtmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter bit HAS_CAPT = 1'b1,
  parameter bit HAS_EXT  = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             extTick,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  output logic             wrErr,
  output logic             irq
);
  dpStrobe_t        stb;
  logic [CNT_W-1:0] constVal, cntVal, captVal;
  logic             cntZero;
  ctrlFields_t      ctrlVal;
  logic             flagVal;

  dtmr_ctrl #(.CNT_W(CNT_W), .HAS_CAPT(HAS_CAPT), .HAS_EXT(HAS_EXT)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .run      (run),
    .extTick  (extTick),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .cntZero  (cntZero),
    .constVal (constVal),
    .cntVal   (cntVal),
    .captVal  (captVal),
    .stb      (stb),
    .rdData   (rdData),
    .wrErr    (wrErr),
    .irq      (irq),
    .ctrlVal  (ctrlVal),
    .flagVal  (flagVal)
  );

  dtmr_datapath #(.CNT_W(CNT_W), .HAS_CAPT(HAS_CAPT)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .constVal (constVal),
    .cntVal   (cntVal),
    .captVal  (captVal),
    .cntZero  (cntZero)
  );
endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             run,
  input logic             wrEn,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] wrData,
  input logic             wrErr,
  input logic             irq,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] constVal,
  input logic [7:0]       ctrlVal,
  input logic             flagVal,
  input logic             tickVal
);
  logic cntWr;
  assign cntWr = wrEn && (addr == 2'd1);

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!run && !cntWr) |=> $stable(cntVal));

  p_tick_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    tickVal |-> run);

  p_dec_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tickVal && cntVal != '0 && !cntWr) |=> (cntVal == $past(cntVal) - 1'b1));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tickVal && cntVal == '0 && !cntWr) |=> (cntVal == $past(constVal) && flagVal));

  p_flag_run_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagVal) |-> $past(run));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (flagVal && !(wrEn && addr == 2'd2 && !wrData[8])) |=> flagVal);

  p_reject_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd2 && wrErr) |=> $stable(ctrlVal));

  p_reject_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrErr && flagVal) |=> flagVal);

  p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> flagVal);
endmodule

bind downcount_timer dtmr_checker #(.CNT_W(CNT_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .run      (run),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .wrErr    (wrErr),
  .irq      (irq),
  .cntVal   (cntVal),
  .constVal (constVal),
  .ctrlVal  (ctrlVal),
  .flagVal  (flagVal),
  .tickVal  (stb.tick)
);

// File: tb/test_downcount_timer.sv
module test_downcount_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        run = 1'b0;
  logic        extTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        wrErr;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  downcount_timer i_downcount_timer (
    .clk(clk), .rstN(rstN), .run(run), .extTick(extTick),
    .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .wrErr(wrErr), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  longint unsigned mConst, mCnt, mCapt;
  int mCode, mEdge, mIe, mCap, mFlag, mPre;

  function automatic bit legalCtrl(logic [31:0] d);
    if (d[31:10] != 0) return 0;
    if (d[2:0] > 4) return 0;          // 5 reserved, 6/7 need the external option
    if (d[4:3] != 0) return 0;
    if (d[7:6] == 1) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] expRd(logic [1:0] a);
    case (a)
      2'd0: return 32'(mConst);
      2'd1: return 32'(mCnt);
      2'd2: return 32'(mCode + mEdge * 8 + mIe * 32 + mCap * 64 + mFlag * 256);
      default: return 32'(mCapt);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mConst = 64'hFFFF_FFFF; mCnt = 64'hFFFF_FFFF; mCapt = 0;
      mCode = 0; mEdge = 0; mIe = 0; mCap = 0; mFlag = 0; mPre = 0;
    end else begin
      int period;
      bit tk, uf, ctrlOk;
      longint unsigned oldConst;
      period = 4 ** (mCode + 1);
      tk = run && (mPre == period - 1);
      uf = tk && (mCnt == 0);
      oldConst = mConst;
      ctrlOk = wrEn && addr == 2'd2 && legalCtrl(wrData);
      if (ctrlOk && int'(wrData[2:0]) != mCode) mPre = 0;
      else if (run) mPre = tk ? 0 : mPre + 1;
      if (wrEn && addr == 2'd0) mConst = wrData;
      if (wrEn && addr == 2'd3) mCapt = wrData;
      if (wrEn && addr == 2'd1) mCnt = wrData;
      else if (tk) mCnt = (mCnt == 0) ? oldConst : mCnt - 1;
      if (uf) mFlag = 1;
      else if (ctrlOk && !wrData[8]) mFlag = 0;
      if (ctrlOk) begin
        mCode = wrData[2:0]; mEdge = wrData[4:3]; mIe = wrData[5]; mCap = wrData[7:6];
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      check("R8 irq level", 32'(irq), 32'(mFlag & mIe));
      check("R9 wrErr", 32'(wrErr), 32'(wrEn && addr == 2'd2 && !legalCtrl(wrData)));
      check("R2 readback", rdData, expRd(addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    wrEn = 1'b0; addr = a;
    #1 check(tag, rdData, exp);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, bit expErr, string tag);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    #1 check(tag, 32'(wrErr), 32'(expErr));
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runFor(int n);
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(2'd0, 32'hFFFF_FFFF, "R1 constant reset");
    rd(2'd1, 32'hFFFF_FFFF, "R1 counter reset");
    rd(2'd2, 32'h0, "R1 control reset");
    check("R1 irq reset", 32'(irq), 32'h0);

    // R2 register map
    wr(2'd0, 32'd5, 1'b0, "R2 write constant");
    wr(2'd1, 32'd2, 1'b0, "R2 write counter");
    wr(2'd3, 32'hA5A5_0001, 1'b0, "R2 write capture");
    rd(2'd0, 32'd5, "R2 constant readback");
    rd(2'd1, 32'd2, "R2 counter readback");
    rd(2'd3, 32'hA5A5_0001, "R2 capture readback");

    // R4 / R5 at divide-by-4
    wr(2'd2, 32'h20, 1'b0, "R10 legal write");
    runFor(4);  rd(2'd1, 32'd1, "R4 decrement");
    runFor(4);  rd(2'd1, 32'd0, "R4 reach zero");
    runFor(4);  rd(2'd1, 32'd5, "R5 reload");
    rd(2'd2, 32'h120, "R5 flag set");
    check("R8 irq with enable", 32'(irq), 32'h1);

    // R6 freeze of counter and prescaler
    runFor(3);
    repeat (10) @(negedge clk);
    rd(2'd1, 32'd5, "R6 counter frozen");
    runFor(1);  rd(2'd1, 32'd4, "R6 prescaler resumed");

    // R7 / R8 flag handling
    wr(2'd2, 32'h120, 1'b0, "R7 keep write");
    rd(2'd2, 32'h120, "R7 flag kept");
    wr(2'd2, 32'h100, 1'b0, "R8 disable write");
    check("R8 irq masked", 32'(irq), 32'h0);
    rd(2'd2, 32'h100, "R8 flag still set");
    wr(2'd2, 32'h020, 1'b0, "R7 clear write");
    rd(2'd2, 32'h020, "R7 flag cleared");
    check("R7 irq after clear", 32'(irq), 32'h0);

    // R3 divide-by-16, restart on code change, divide-by-1024
    wr(2'd1, 32'd3, 1'b0, "R3 load counter");
    wr(2'd2, 32'h21, 1'b0, "R3 code 1");
    runFor(15); rd(2'd1, 32'd3, "R3 no tick before 16");
    runFor(1);  rd(2'd1, 32'd2, "R3 tick at 16");
    runFor(10);
    wr(2'd2, 32'h20, 1'b0, "R3 code 0");
    runFor(3);  rd(2'd1, 32'd2, "R3 restart no early tick");
    runFor(1);  rd(2'd1, 32'd1, "R3 tick after restart");
    wr(2'd2, 32'h24, 1'b0, "R3 code 4");
    runFor(1023); rd(2'd1, 32'd1, "R3 no tick before 1024");
    runFor(1);    rd(2'd1, 32'd0, "R3 tick at 1024");

    // set the flag again for the rejection tests
    wr(2'd2, 32'h20, 1'b0, "R3 back to code 0");
    runFor(4);
    rd(2'd2, 32'h120, "R5 flag set again");

    // R9 illegal control writes (all with bit 8 clear)
    wr(2'd2, 32'h0000_0420, 1'b1, "R9 reserved bit 10");
    wr(2'd2, 32'h0000_0025, 1'b1, "R9 divider code 5");
    wr(2'd2, 32'h0000_0026, 1'b1, "R9 code 6 without external");
    wr(2'd2, 32'h0000_0028, 1'b1, "R9 edge select");
    wr(2'd2, 32'h0000_0060, 1'b1, "R9 capture control 1");
    wr(2'd2, 32'h0001_0020, 1'b1, "R9 upper bit 16");
    rd(2'd2, 32'h120, "R9 control and flag unchanged");
    check("R9 irq unchanged", 32'(irq), 32'h1);

    // R10 capture fields
    wr(2'd2, 32'h1A0, 1'b0, "R10 capture control 2");
    rd(2'd2, 32'h1A0, "R10 capture control stored");
    wr(2'd2, 32'h3E0, 1'b0, "R10 bit 9 written");
    rd(2'd2, 32'h1E0, "R10 bit 9 discarded");

    // R7 underflow wins over a clearing write in the same cycle
    wr(2'd2, 32'h020, 1'b0, "R7 clear before race");
    wr(2'd1, 32'd0, 1'b0, "R7 counter to zero");
    @(negedge clk);
    run = 1'b1;
    repeat (3) @(negedge clk);
    wrEn = 1'b1; addr = 2'd2; wrData = 32'h020;
    @(negedge clk);
    run = 1'b0; wrEn = 1'b0;
    rd(2'd2, 32'h120, "R7 underflow beats clear");
    rd(2'd1, 32'd5, "R5 reload in race");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule